// File: doc/BRIEF.md
# Two-Wire EEPROM Byte Engine

This block is a serial master for a two-wire EEPROM bus, run one byte at a time by a host. The host loads a byte into the data register and writes a four-bit command code. The engine then clocks one byte out or in on the serial clock and data lines, handles the acknowledge bit, and updates a status byte. That byte holds the error, busy, received-acknowledge and sent-acknowledge flags, plus the last accepted command code.

The serial clock comes from a divider of the system clock and is held high whenever no byte is moving. The data line is open-drain: the engine only pulls it low (`sda_oe`) and reads its level back (`sda_in`). A transmit issued while the bus is idle puts a START on the bus first. The STOP command returns the bus to idle. A one-cycle interrupt marks the end of every bus operation.

Top module: `eeprom_byte_master`

## Requirements
- R1: After reset, `status_q` reads 0x30, `data_q` reads 0x00, `scl` is 1, `sda_oe` is 0 and `irq` is 0. The fields of `status_q` are: bit 7 error, bit 6 busy, bit 5 received-ACK flag (0 = slave acknowledged), bit 4 sent-ACK flag (0 = ACK sent by the engine), bits 3:0 last accepted command.
- R2: Command 0011 sends the data register MSB first, eight bits, followed by one acknowledge clock. If the bus is idle (after reset or after a STOP), a START comes first: SDA falls while SCL is high. The data line changes only while SCL is low, except at START and STOP.
- R3: After command 0011, bit 5 holds the level sampled on SDA during the ninth clock: 0 if the slave acknowledged, 1 if it did not.
- R4: Command 0010 shifts eight bits from SDA into the data register, MSB first, and then drives SDA low for one acknowledge clock. Bit 4 reads 0 once that acknowledge is sent.
- R5: Command 0101 produces a STOP (SDA rises while SCL is high) and leaves the bus idle, so the next transmit starts with a fresh START.
- R6: Command 0000 causes no bus activity and no busy period, and clears the error flag.
- R7: Any code other than 0000, 0010, 0011 and 0101 sets the error flag, causes no bus activity and no busy period. The next legal command clears the error flag.
- R8: Busy is 1 from the cycle after a bus command is accepted until the operation ends. `irq` is high for exactly one cycle: the first cycle in which busy reads 0 again.
- R9: During a transfer, one SCL period lasts 4×`QTR_CYC` system clocks. Whenever busy is 0, SCL is 1.
- R10: Command writes and data writes made while busy is 1 are ignored.
- R11: Bits 3:0 of `status_q` show the last command code accepted, illegal codes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Byte to load into the data register |
| wr_cmd_en | input | 1 | Write strobe for the command field |
| wr_cmd | input | 4 | Command code |
| data_q | output | 8 | Data register (byte sent or byte received) |
| status_q | output | 8 | Error, busy, ACK flags and last command |
| irq | output | 1 | One-cycle pulse at the end of a bus operation |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
Some properties are checked on every cycle:
- SCL stays high whenever the engine is idle.
- The data-line driver changes while SCL is high only inside a START or STOP frame.
- The interrupt coincides with the fall of busy and lasts one cycle.
- The error flag never appears together with busy.
- Command writes during busy leave the command field untouched.

Other behaviour needs the bench's bus model, which acts as an EEPROM on the open-drain line:
- the bit order and the byte value sent;
- the acknowledge sampling and the acknowledge driven;
- START and STOP placement;
- the measured SCL period.

// File: rtl/ee2w_pkg.sv
// Shared constants and types for the two-wire EEPROM byte engine.
// Assumes an 8-bit data path and a 4-bit command code.
package ee2w_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 4;

    // Status bit positions; the host decodes them, so they are fixed
    localparam int ST_ERR   = 7;
    localparam int ST_BUSY  = 6;
    localparam int ST_RXACK = 5;
    localparam int ST_TXACK = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_HALT  = 4'b0000,
        CMD_READ  = 4'b0010,
        CMD_WRITE = 4'b0011,
        CMD_STOP  = 4'b0101
    } cmd_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_TX   = 2'd1,
        OP_RX   = 2'd2,
        OP_STOP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FR_START = 2'd0,
        FR_DATA  = 2'd1,
        FR_ACK   = 2'd2,
        FR_STOP  = 2'd3
    } frame_e;
endpackage

// File: rtl/ee2w_cmd_decode.sv
// Maps a host command code to a bus operation and a legality flag.
// Purely combinational; assumes the code is sampled only on an accepted write.
module ee2w_cmd_decode
    import ee2w_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output op_e              op,
    output logic             legal
);
    timeunit 1ns;
    timeprecision 1ps;

    // Decode the code into an operation; unknown codes are illegal
    always_comb begin
        op    = OP_NONE;
        legal = 1'b1;
        case (code)
            CMD_HALT:  op = OP_NONE;
            CMD_READ:  op = OP_RX;
            CMD_WRITE: op = OP_TX;
            CMD_STOP:  op = OP_STOP;
            default:   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ee2w_quarter_tick.sv
// Produces one-cycle ticks spaced QTR_CYC system clocks apart while run is high.
// The counter restarts whenever run is low, so the first tick comes QTR_CYC
// cycles after run rises.
module ee2w_quarter_tick #(
    parameter  int QTR_CYC = 320,
    localparam int CNT_W   = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(QTR_CYC - 1));

    // Count system clocks within one quarter of the serial clock period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ee2w_bit_seq.sv
// Bit-level sequencer. Each frame (START, data bit, ACK, STOP) spans four
// quarter ticks:
//   q0 lowers SCL, q1 sets SDA, q2 raises SCL, q3 samples or finishes.
// START and STOP move SDA while SCL is high. SCL is left high after every
// operation. Assumes launch is asserted only while busy is low.
module ee2w_bit_seq
    import ee2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  op_e               launch_op,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              finish,
    output op_e               cur_op,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl,
    output logic              sda_oe,
    output logic              edge_frame
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(BYTE_W);

    frame_e            frame;
    logic [1:0]        ph;
    logic [IDX_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              bus_open;

    assign finish     = busy && tick && (ph == 2'd3) && (frame == FR_ACK || frame == FR_STOP);
    assign rx_byte    = shreg;
    assign edge_frame = (frame == FR_START) || (frame == FR_STOP);

    // Step through the frames of one operation on each quarter tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_op   <= OP_NONE;
            frame    <= FR_DATA;
            ph       <= 2'd0;
            bit_idx  <= IDX_W'(BYTE_W - 1);
            shreg    <= '0;
            bus_open <= 1'b0;
            scl      <= 1'b1;
            sda_oe   <= 1'b0;
        end else if (launch && !busy) begin
            busy    <= 1'b1;
            cur_op  <= launch_op;
            shreg   <= tx_byte;
            ph      <= 2'd0;
            bit_idx <= IDX_W'(BYTE_W - 1);
            if (launch_op == OP_STOP)                   frame <= FR_STOP;
            else if (launch_op == OP_TX && !bus_open)   frame <= FR_START;
            else                                        frame <= FR_DATA;
        end else if (busy && tick) begin
            ph <= ph + 2'd1;
            case (frame)
                FR_START: begin
                    if (ph == 2'd0) sda_oe <= 1'b1;
                    if (ph == 2'd3) begin
                        frame    <= FR_DATA;
                        bus_open <= 1'b1;
                    end
                end
                FR_DATA: begin
                    case (ph)
                        2'd0: scl <= 1'b0;
                        2'd1: sda_oe <= (cur_op == OP_TX) ? ~shreg[BYTE_W-1] : 1'b0;
                        2'd2: scl <= 1'b1;
                        default: begin
                            shreg <= {shreg[BYTE_W-2:0], (cur_op == OP_RX) ? sda_in : 1'b0};
                            if (bit_idx == '0) frame <= FR_ACK;
                            else               bit_idx <= bit_idx - IDX_W'(1);
                        end
                    endcase
                end
                FR_ACK: begin
                    case (ph)
                        2'd0: scl <= 1'b0;
                        2'd1: sda_oe <= (cur_op == OP_RX);
                        2'd2: scl <= 1'b1;
                        default: busy <= 1'b0;
                    endcase
                end
                FR_STOP: begin
                    case (ph)
                        2'd0: scl <= 1'b0;
                        2'd1: sda_oe <= 1'b1;
                        2'd2: scl <= 1'b1;
                        default: begin
                            sda_oe   <= 1'b0;
                            bus_open <= 1'b0;
                            busy     <= 1'b0;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/eeprom_byte_master.sv
// Top of the two-wire EEPROM byte engine. Holds the data register and the
// status flags, accepts host commands while idle and raises a one-cycle
// interrupt when a bus operation ends. SDA is open-drain: sda_oe pulls low.
module eeprom_byte_master
    import ee2w_pkg::*;
#(
    parameter int QTR_CYC = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_cmd_en,
    input  logic [CMD_W-1:0]  wr_cmd,
    output logic [BYTE_W-1:0] data_q,
    output logic [7:0]        status_q,
    output logic              irq,
    output logic              scl,
    output logic              sda_oe,
    input  logic              sda_in
);
    timeunit 1ns;
    timeprecision 1ps;

    op_e               dec_op;
    logic              dec_legal;
    logic              tick;
    logic              busy;
    logic              finish;
    op_e               cur_op;
    logic [BYTE_W-1:0] rx_byte;
    logic              seq_edge_frame;
    logic              accept;
    logic              launch;

    logic [BYTE_W-1:0] data_r;
    logic              err_r;
    logic              rxack_r;
    logic              txack_r;
    logic [CMD_W-1:0]  cmd_r;
    logic              irq_r;

    ee2w_cmd_decode i_dec (
        .code  (wr_cmd),
        .op    (dec_op),
        .legal (dec_legal)
    );

    ee2w_quarter_tick #(.QTR_CYC(QTR_CYC)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ee2w_bit_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_op  (dec_op),
        .tx_byte    (data_r),
        .tick       (tick),
        .sda_in     (sda_in),
        .busy       (busy),
        .finish     (finish),
        .cur_op     (cur_op),
        .rx_byte    (rx_byte),
        .scl        (scl),
        .sda_oe     (sda_oe),
        .edge_frame (seq_edge_frame)
    );

    assign accept = wr_cmd_en && !busy;
    assign launch = accept && dec_legal && (dec_op != OP_NONE);

    // Host registers, status flags and the end-of-operation interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_r  <= '0;
            err_r   <= 1'b0;
            rxack_r <= 1'b1;
            txack_r <= 1'b1;
            cmd_r   <= '0;
            irq_r   <= 1'b0;
        end else begin
            irq_r <= finish;
            if (wr_data_en && !busy) data_r <= wr_data;
            if (accept) begin
                cmd_r <= wr_cmd;
                err_r <= !dec_legal;
                if (dec_legal && dec_op == OP_RX) txack_r <= 1'b1;
            end
            if (finish) begin
                case (cur_op)
                    OP_TX: rxack_r <= sda_in;
                    OP_RX: begin
                        data_r  <= rx_byte;
                        txack_r <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign data_q   = data_r;
    assign irq      = irq_r;
    assign status_q = {err_r, busy, rxack_r, txack_r, cmd_r};
endmodule

// File: rtl/ee2w_checker.sv
// Cycle-level properties of the EEPROM byte engine, bound to the top module.
// Assumes a synchronous active-low reset.
module ee2w_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       err,
    input logic       irq,
    input logic       scl,
    input logic       sda_oe,
    input logic       edge_frame,
    input logic       wr_cmd_en,
    input logic [3:0] cmd_field
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_SCL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> scl); // R9

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && (sda_oe != $past(sda_oe))) |-> edge_frame); // R2

    AST_IRQ_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq); // R8

    AST_IRQ_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(busy) && !busy)); // R8

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8

    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R7

    AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd_en) |=> ($stable(cmd_field) && $stable(err))); // R10
endmodule

bind eeprom_byte_master ee2w_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (status_q[6]),
    .err        (status_q[7]),
    .irq        (irq),
    .scl        (scl),
    .sda_oe     (sda_oe),
    .edge_frame (seq_edge_frame),
    .wr_cmd_en  (wr_cmd_en),
    .cmd_field  (status_q[3:0])
);

// File: tb/test_eeprom_byte_master.sv
// Self-checking bench: an open-drain bus with a behavioural EEPROM model,
// a table of command vectors, then directed corner cases.
module test_eeprom_byte_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int QTR = 3;
    localparam real PER_NS = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_cmd_en = 1'b0;
    logic [3:0] wr_cmd = '0;
    logic [7:0] data_q;
    logic [7:0] status_q;
    logic       irq;
    logic       scl;
    logic       sda_oe;
    logic       sda;

    // Bus model state
    logic       pull = 1'b0;
    logic       slv_tx = 1'b0;
    logic       slv_nack = 1'b0;
    logic [7:0] slv_byte = '0;
    logic [7:0] shift = '0;
    logic [7:0] got = '0;
    logic       ack_seen = 1'b0;
    int         bitcnt = 0;
    int         starts = 0;
    int         stops = 0;
    int         scl_falls = 0;
    int         irq_cnt = 0;
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b1;
    realtime    last_rise = 0.0;
    realtime    scl_per = 0.0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    assign sda = !(sda_oe || pull);

    eeprom_byte_master #(.QTR_CYC(QTR)) i_eeprom_byte_master (
        .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_cmd_en(wr_cmd_en), .wr_cmd(wr_cmd), .data_q(data_q), .status_q(status_q),
        .irq(irq), .scl(scl), .sda_oe(sda_oe), .sda_in(sda)
    );

    always #2.5 clk = ~clk;

    // EEPROM model: START/STOP detection, bit shifting and ACK handling
    always @(scl, sda) begin
        if (scl && prev_scl && prev_sda && !sda) begin
            starts++; bitcnt = 0;
        end else if (scl && prev_scl && !prev_sda && sda) begin
            stops++; bitcnt = 0;
        end else if (!scl && prev_scl) begin
            scl_falls++;
            if (slv_tx) pull = (bitcnt < 8) ? !slv_byte[7-bitcnt] : 1'b0;
            else        pull = (bitcnt == 8) && !slv_nack;
        end else if (scl && !prev_scl) begin
            scl_per = $realtime - last_rise;
            last_rise = $realtime;
            if (bitcnt < 8) shift = {shift[6:0], sda};
            else if (slv_tx) ack_seen = !sda;
            else got = shift;
            bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_data(input logic [7:0] d);
        @(negedge clk); wr_data_en = 1'b1; wr_data = d;
        @(negedge clk); wr_data_en = 1'b0;
    endtask

    task automatic write_cmd(input logic [3:0] c);
        @(negedge clk); wr_cmd_en = 1'b1; wr_cmd = c;
        @(negedge clk); wr_cmd_en = 1'b0;
    endtask

    // Wait for busy to drop; the interrupt must be high in that first idle cycle
    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!status_q[6]) begin
                seen = 1'b1;
                check({req, " irq at busy fall"}, 32'(irq), 32'd1);
                break;
            end
        end
        if (!seen) check({req, " busy never fell"}, 32'd0, 32'd1);
    endtask

    typedef struct packed {
        logic [3:0] cmd;
        logic [7:0] data;
        logic       s_tx;
        logic       s_nack;
        logic [7:0] s_byte;
        logic [7:0] exp_st;
        logic [7:0] exp_data;
        logic       cap;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{4'h3, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h13, 8'hA5, 1'b1},
        '{4'h3, 8'h3C, 1'b0, 1'b1, 8'h00, 8'h33, 8'h3C, 1'b1},
        '{4'h2, 8'h00, 1'b1, 1'b0, 8'h96, 8'h22, 8'h96, 1'b0},
        '{4'h7, 8'h5A, 1'b0, 1'b0, 8'h00, 8'hA7, 8'h5A, 1'b0},
        '{4'h5, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h25, 8'h5A, 1'b0},
        '{4'h3, 8'h01, 1'b0, 1'b0, 8'h00, 8'h03, 8'h01, 1'b1},
        '{4'h0, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0},
        '{4'hF, 8'h01, 1'b0, 1'b0, 8'h00, 8'h8F, 8'h01, 1'b0},
        '{4'h0, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 status", 32'(status_q), 32'h30);
        check("R1 data", 32'(data_q), 32'h00);
        check("R1 scl", 32'(scl), 32'd1);
        check("R1 sda_oe", 32'(sda_oe), 32'd0);
        check("R1 irq", 32'(irq), 32'd0);

        for (int v = 0; v < 9; v++) begin
            int falls0;
            int irq0;
            bit bus_cmd;
            slv_tx = VEC[v].s_tx;
            slv_nack = VEC[v].s_nack;
            slv_byte = VEC[v].s_byte;
            bus_cmd = (VEC[v].cmd == 4'h2) || (VEC[v].cmd == 4'h3) || (VEC[v].cmd == 4'h5);
            write_data(VEC[v].data);
            falls0 = scl_falls;
            irq0 = irq_cnt;
            write_cmd(VEC[v].cmd);
            if (bus_cmd) begin
                check("R8 busy after accept", 32'(status_q[6]), 32'd1);
                wait_done("R8");
                @(negedge clk);
                check("R8 single irq", 32'(irq_cnt - irq0), 32'd1);
                check("R9 scl idle high", 32'(scl), 32'd1);
            end else begin
                check("R6 R7 no busy", 32'(status_q[6]), 32'd0);
                repeat (4 * QTR) @(negedge clk);
                check("R6 R7 no scl activity", 32'(scl_falls - falls0), 32'd0);
                check("R6 R7 no irq", 32'(irq_cnt - irq0), 32'd0);
            end
            check("R3 R4 R6 R7 R11 status", 32'(status_q), 32'(VEC[v].exp_st));
            check("R4 data register", 32'(data_q), 32'(VEC[v].exp_data));
            if (VEC[v].cap) check("R2 byte on bus MSB first", 32'(got), 32'(VEC[v].data));
            if (v == 0) begin
                check("R2 START before first transmit", 32'(starts), 32'd1);
                check("R9 scl period", 32'(int'(scl_per / PER_NS)), 32'(4 * QTR));
            end
            if (v == 1) check("R2 no START while bus open", 32'(starts), 32'd1);
            if (v == 2) check("R4 ACK driven by engine", 32'(ack_seen), 32'd1);
            if (v == 4) check("R5 STOP seen", 32'(stops), 32'd1);
            if (v == 5) check("R5 START after STOP", 32'(starts), 32'd2);
        end

        // R10: command and data writes during busy are ignored
        slv_tx = 1'b0; slv_nack = 1'b0;
        write_data(8'h55);
        write_cmd(4'h3);
        repeat (3) @(negedge clk);
        write_cmd(4'h7);
        write_data(8'hFF);
        wait_done("R10");
        @(negedge clk);
        check("R10 status untouched by busy write", 32'(status_q), 32'h03);
        check("R10 data untouched by busy write", 32'(data_q), 32'h55);
        check("R10 byte sent", 32'(got), 32'h55);

        // R7: error cleared by the following legal command
        write_cmd(4'h9);
        check("R7 error set", 32'(status_q[7]), 32'd1);
        write_cmd(4'h5);
        check("R7 error cleared by legal command", 32'(status_q[7]), 32'd0);
        wait_done("R5");
        check("R5 STOP count", 32'(stops), 32'd2);

        finish_run();
    end
endmodule